// File: doc/BRIEF.md
# TDM Time-Slot Routing Engine

This block sits between an already-framed TDM serial line and five internal serial channels. A bit-position index, a frame-start marker and a bit-enable strobe come from an external framer. The block works out which channel owns the current 8-bit time slot. On receive it assembles the slot's byte and hands it to that channel with a one-cycle strobe. On transmit it takes a byte from the owning channel and shifts it out. Slots that no channel owns are dropped on receive and left undriven (idle high) on transmit.

Slot ownership comes from two route tables, one for receive and one for transmit, each up to 64 entries long. An entry is a run: a count of consecutive slots plus a channel code. The engine walks the list in order from slot 0 of every frame, so a whole frame can be described with a few entries. Tables are written through a single-cycle write port into a shadow copy. The shadow becomes the working table only at the next frame start, so the frame in progress always routes with one consistent table.

Top module: `tdm_slot_router`

## Requirements
- R1: Route entries apply in index order starting at slot 0 of each frame. An entry with run field `n` (6 bits, `cfg_run`) covers `n+1` consecutive slots.
- R2: A received slot byte is assembled MSB first: the bit with `bit_idx`=0 is byte bit 7. In the cycle after the slot's last bit (`bit_idx`=7), `rx_byte` holds the byte and only `rx_stb[c-1]` is high for one cycle, where `c` is the slot's channel code.
- R3: Codes 1 to 5 name channels. Code 0, and the illegal codes 6 and 7, mark a slot unused. Such a slot raises no `rx_stb` and no `tx_take`, and on transmit it holds `tx_en` low and `tx_bit` high.
- R4: Slots after the entry whose `cfg_last` bit is set, or after entry 63, are unused until the next frame start. Every frame start rewinds the walk to entry 0.
- R5: For a transmit slot whose channel has `tx_rdy` high at the slot's first bit, the matching byte of `tx_din` (channel `c` at bits `8(c-1)+7 .. 8(c-1)`) is sent MSB first. `tx_take[c-1]` pulses in the cycle after that first bit. Each `tx_bit`/`tx_en` value appears in the cycle after its `bit_en` edge.
- R6: A channel whose `tx_rdy` is low at its slot's first bit gets 8'hFF sent with `tx_en` high and no `tx_take`. Its `tx_underrun` bit is set. All underrun bits clear at the next frame start, unless an underrun occurs in that frame's first slot.
- R7: `cfg_dir`=0 writes the receive table and `cfg_dir`=1 writes the transmit table. The two tables route independently.
- R8: A table write takes effect at the first frame start after the write's cycle. A write in the frame-start cycle itself waits one more frame.
- R9: Cycles with `bit_en` low change nothing. The shift state, walk position and outputs hold, and no strobes occur.
- R10: After reset, both tables mark every slot unused, all strobes are low, `tx_bit` is 1, `tx_en` is 0 and `tx_underrun` is 0.
- R11: A run field of 63 covers 64 slots. A table of 64 single-slot entries with no last flag routes slots 0 to 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One TDM bit is present this cycle |
| bit_idx | input | 3 | Bit position in the slot, 0 = first (MSB) |
| frame_start | input | 1 | With `bit_en`: first bit of slot 0 |
| rx_bit | input | 1 | Received serial bit |
| cfg_we | input | 1 | Table write strobe |
| cfg_dir | input | 1 | 0 = receive table, 1 = transmit table |
| cfg_idx | input | 6 | Entry index |
| cfg_run | input | 6 | Slot count minus one |
| cfg_code | input | 3 | Channel code |
| cfg_last | input | 1 | Entry ends the table |
| tx_din | input | 40 | Transmit bytes, channel c at bits 8(c-1)+7..8(c-1) |
| tx_rdy | input | 5 | Channel has a transmit byte ready |
| rx_byte | output | 8 | Last delivered receive byte |
| rx_stb | output | 5 | Per-channel receive strobe |
| tx_take | output | 5 | Per-channel transmit byte consumed |
| tx_bit | output | 1 | Transmitted serial bit |
| tx_en | output | 1 | Transmit line driven this bit |
| tx_underrun | output | 5 | Per-channel underrun in current frame |

## Verification
The routing is tried with tables that mix unused runs, an illegal code, multi-slot runs and a last-entry flag, over frames longer than the table. This separates the run-length walk from the trailing unused region. The receive and transmit tables are given different layouts, so a swapped or shared table shows up. The same frame is repeated with bit-enable gaps and partial channel readiness, which splits stalls from underruns. Writes placed mid-frame and in the frame-start cycle separate deferred from immediate table updates. A 64-slot run and a full 64-entry table probe the counter and pointer limits.

// File: rtl/tdm_route_pkg.sv
package tdm_route_pkg;
  localparam int NUM_CH  = 5;
  localparam int CODE_W  = 3;
  localparam int RUN_W   = 6;
  localparam int BYTE_W  = 8;
  localparam int BIT_W   = $clog2(BYTE_W);

  typedef struct packed {
    logic [RUN_W-1:0]  run;
    logic [CODE_W-1:0] code;
    logic              last;
  } route_ent_t;

  localparam route_ent_t EMPTY_ENT = '{run: '0, code: '0, last: 1'b1};

  // map illegal codes onto "unused"
  function automatic logic [CODE_W-1:0] legal_code(input logic [CODE_W-1:0] c);
    return (c >= CODE_W'(1) && c <= CODE_W'(NUM_CH)) ? c : '0;
  endfunction

  function automatic logic [NUM_CH-1:0] code_onehot(input logic [CODE_W-1:0] c);
    logic [NUM_CH-1:0] v;
    for (int i = 0; i < NUM_CH; i++) v[i] = (c == CODE_W'(i + 1));
    return v;
  endfunction
endpackage

// File: rtl/tdm_route_table.sv
module tdm_route_table
  import tdm_route_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int DIR_SEL = 0,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_dir,
  input  logic [IDX_W-1:0] wr_idx,
  input  route_ent_t       wr_ent,
  input  logic             commit,
  input  logic [IDX_W-1:0] rd_idx,
  output route_ent_t       rd_ent,
  output route_ent_t       head_ent
);
  route_ent_t shadow [DEPTH];
  route_ent_t active [DEPTH];

  logic wr_hit;
  assign wr_hit = wr_en && (wr_dir == DIR_SEL[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        shadow[i] <= EMPTY_ENT;
        active[i] <= EMPTY_ENT;
      end
    end else begin
      if (wr_hit) shadow[wr_idx] <= wr_ent;
      if (commit) begin
        for (int i = 0; i < DEPTH; i++) active[i] <= shadow[i];
      end
    end
  end

  assign rd_ent   = active[rd_idx];
  assign head_ent = shadow[0];
endmodule

// File: rtl/tdm_run_walker.sv
module tdm_run_walker
  import tdm_route_pkg::*;
#(
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic              frame_start,
  output logic [IDX_W-1:0]  rd_idx,
  input  route_ent_t        rd_ent,
  input  route_ent_t        head_ent,
  output logic [CODE_W-1:0] chan_now
);
  logic [IDX_W-1:0] ptr;
  logic [RUN_W-1:0] used;
  logic             walk_done;
  logic             first_bit;
  logic             slot_tail;
  logic             run_over;

  assign first_bit = bit_en && frame_start;
  assign slot_tail = bit_en && (bit_idx == BIT_W'(BYTE_W - 1));
  assign run_over  = (used == rd_ent.run);
  assign rd_idx    = ptr;

  // the table copies at the frame start, so slot 0 reads the shadow head
  always_comb begin
    if (first_bit)      chan_now = legal_code(head_ent.code);
    else if (walk_done) chan_now = '0;
    else                chan_now = legal_code(rd_ent.code);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr       <= '0;
      used      <= '0;
      walk_done <= 1'b1;
    end else if (first_bit) begin
      ptr       <= '0;
      used      <= '0;
      walk_done <= 1'b0;
    end else if (slot_tail && !walk_done) begin
      if (run_over) begin
        used <= '0;
        if (rd_ent.last || ptr == IDX_W'(DEPTH - 1)) walk_done <= 1'b1;
        else                                         ptr <= ptr + 1'b1;
      end else begin
        used <= used + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdm_rx_demux.sv
module tdm_rx_demux
  import tdm_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic [CODE_W-1:0] chan_now,
  input  logic              rx_bit,
  output logic [BYTE_W-1:0] rx_byte,
  output logic [NUM_CH-1:0] rx_stb
);
  logic [BYTE_W-2:0] sh;
  logic [CODE_W-1:0] slot_chan;
  logic              slot_head;
  logic              slot_tail;

  assign slot_head = bit_en && (bit_idx == '0);
  assign slot_tail = bit_en && (bit_idx == BIT_W'(BYTE_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh        <= '0;
      slot_chan <= '0;
      rx_byte   <= '0;
      rx_stb    <= '0;
    end else begin
      rx_stb <= '0;
      if (bit_en) sh <= {sh[BYTE_W-3:0], rx_bit};
      if (slot_head) slot_chan <= chan_now;
      if (slot_tail && slot_chan != '0) begin
        rx_byte <= {sh, rx_bit};
        rx_stb  <= code_onehot(slot_chan);
      end
    end
  end
endmodule

// File: rtl/tdm_tx_mux.sv
module tdm_tx_mux
  import tdm_route_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bit_en,
  input  logic [BIT_W-1:0]         bit_idx,
  input  logic                     frame_start,
  input  logic [CODE_W-1:0]        chan_now,
  input  logic [NUM_CH*BYTE_W-1:0] tx_din,
  input  logic [NUM_CH-1:0]        tx_rdy,
  output logic [NUM_CH-1:0]        tx_take,
  output logic                     tx_bit,
  output logic                     tx_en,
  output logic [NUM_CH-1:0]        tx_underrun
);
  logic [NUM_CH-1:0] sel_oh;
  logic [NUM_CH-1:0] miss_vec;
  logic [BYTE_W-1:0] pick;
  logic [BYTE_W-1:0] load_byte;
  logic [BYTE_W-2:0] sh;
  logic              slot_head;
  logic              hit;

  assign slot_head = bit_en && (bit_idx == '0);
  assign sel_oh    = code_onehot(chan_now);
  assign hit       = |(sel_oh & tx_rdy);
  assign miss_vec  = slot_head ? (sel_oh & ~tx_rdy) : '0;
  assign load_byte = hit ? pick : '1;

  always_comb begin
    pick = '1;
    for (int c = 0; c < NUM_CH; c++)
      if (sel_oh[c]) pick = tx_din[c*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh          <= '1;
      tx_bit      <= 1'b1;
      tx_en       <= 1'b0;
      tx_take     <= '0;
      tx_underrun <= '0;
    end else begin
      tx_take <= '0;
      if (bit_en) begin
        tx_underrun <= (frame_start ? '0 : tx_underrun) | miss_vec;
        if (slot_head) begin
          tx_bit  <= load_byte[BYTE_W-1];
          sh      <= load_byte[BYTE_W-2:0];
          tx_en   <= |sel_oh;
          tx_take <= sel_oh & tx_rdy;
        end else begin
          tx_bit <= sh[BYTE_W-2];
          sh     <= {sh[BYTE_W-3:0], 1'b1};
        end
      end
    end
  end
endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router
  import tdm_route_pkg::*;
#(
  parameter int ENT_DEPTH = 64,
  localparam int IDX_W    = $clog2(ENT_DEPTH),
  localparam int DIN_W    = NUM_CH * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic              frame_start,
  input  logic              rx_bit,
  input  logic              cfg_we,
  input  logic              cfg_dir,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [RUN_W-1:0]  cfg_run,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              cfg_last,
  input  logic [DIN_W-1:0]  tx_din,
  input  logic [NUM_CH-1:0] tx_rdy,
  output logic [BYTE_W-1:0] rx_byte,
  output logic [NUM_CH-1:0] rx_stb,
  output logic [NUM_CH-1:0] tx_take,
  output logic              tx_bit,
  output logic              tx_en,
  output logic [NUM_CH-1:0] tx_underrun
);
  route_ent_t        wr_ent;
  route_ent_t        rd_ent   [2];
  route_ent_t        head_ent [2];
  logic [IDX_W-1:0]  rd_idx   [2];
  logic [CODE_W-1:0] chan_now [2];
  logic              commit;

  assign wr_ent = '{run: cfg_run, code: cfg_code, last: cfg_last};
  assign commit = bit_en && frame_start;

  // direction 0 = receive, 1 = transmit
  for (genvar d = 0; d < 2; d++) begin : g_dir
    tdm_route_table #(.DEPTH(ENT_DEPTH), .DIR_SEL(d)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_dir   (cfg_dir),
      .wr_idx   (cfg_idx),
      .wr_ent   (wr_ent),
      .commit   (commit),
      .rd_idx   (rd_idx[d]),
      .rd_ent   (rd_ent[d]),
      .head_ent (head_ent[d])
    );

    tdm_run_walker #(.DEPTH(ENT_DEPTH)) u_walk (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_en      (bit_en),
      .bit_idx     (bit_idx),
      .frame_start (frame_start),
      .rd_idx      (rd_idx[d]),
      .rd_ent      (rd_ent[d]),
      .head_ent    (head_ent[d]),
      .chan_now    (chan_now[d])
    );
  end

  tdm_rx_demux u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .bit_idx  (bit_idx),
    .chan_now (chan_now[0]),
    .rx_bit   (rx_bit),
    .rx_byte  (rx_byte),
    .rx_stb   (rx_stb)
  );

  tdm_tx_mux u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .bit_idx     (bit_idx),
    .frame_start (frame_start),
    .chan_now    (chan_now[1]),
    .tx_din      (tx_din),
    .tx_rdy      (tx_rdy),
    .tx_take     (tx_take),
    .tx_bit      (tx_bit),
    .tx_en       (tx_en),
    .tx_underrun (tx_underrun)
  );
endmodule

// File: rtl/tdm_slot_router_chk.sv
module tdm_slot_router_chk
  import tdm_route_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bit_en,
  input logic [BIT_W-1:0]  bit_idx,
  input logic [NUM_CH-1:0] rx_stb,
  input logic [NUM_CH-1:0] tx_take,
  input logic              tx_bit,
  input logic              tx_en,
  input logic [NUM_CH-1:0] tx_underrun
);
  // R2
  rx_stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_stb));

  // R2
  rx_stb_after_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stb != '0) |-> $past(bit_en && bit_idx == BIT_W'(BYTE_W - 1)));

  // R5
  tx_take_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_take));

  // R5
  tx_take_after_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take != '0) |-> $past(bit_en && bit_idx == '0));

  // R3
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> tx_bit);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(tx_bit) && $stable(tx_en) && rx_stb == '0 && tx_take == '0));

  // R6
  underrun_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take & tx_underrun & ~$past(tx_underrun)) == '0);
endmodule

bind tdm_slot_router tdm_slot_router_chk u_chk (.*);

// File: tb/tdm_slot_router_test.sv
`timescale 1ns/1ps
module tdm_slot_router_test;
  import tdm_route_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        bit_en, frame_start, rx_bit;
  logic [2:0]  bit_idx;
  logic        cfg_we, cfg_dir, cfg_last;
  logic [5:0]  cfg_idx, cfg_run;
  logic [2:0]  cfg_code;
  logic [39:0] tx_din;
  logic [4:0]  tx_rdy;
  logic [7:0]  rx_byte;
  logic [4:0]  rx_stb, tx_take, tx_underrun;
  logic        tx_bit, tx_en;

  tdm_slot_router uut (.*);

  int checks = 0, fails = 0, fid = 0;
  int p_run [2][64], p_code [2][64], a_run [2][64], a_code [2][64];
  bit p_last [2][64], a_last [2][64];
  int rxq_ch [$];
  logic [7:0] rxq_b [$];
  int txq_take [$], txq_en [$], txq_ch [$];
  logic [7:0] txq_b [$];
  logic [4:0] exp_ur;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int model_chan(input int d, input int s);
    int acc = 0;
    for (int e = 0; e < 64; e++) begin
      if (s < acc + a_run[d][e] + 1)
        return (a_code[d][e] >= 1 && a_code[d][e] <= 5) ? a_code[d][e] : 0;
      acc += a_run[d][e] + 1;
      if (a_last[d][e]) return 0;
    end
    return 0;
  endfunction

  function automatic logic [7:0] rx_val(input int s);
    return 8'((s * 29 + fid * 53 + 7) & 255);
  endfunction

  function automatic logic [7:0] din_val(input int c, input int s);
    return 8'((c * 41 + s * 13 + fid * 3 + 1) & 255);
  endfunction

  task automatic set_pend(input int d, input int i, input int run, input int code, input bit last);
    p_run[d][i] = run; p_code[d][i] = code; p_last[d][i] = last;
  endtask

  task automatic cfg_write(input int d, input int i, input int run, input int code, input bit last);
    @(negedge clk);
    cfg_we = 1'b1; cfg_dir = d[0]; cfg_idx = 6'(i); cfg_run = 6'(run);
    cfg_code = 3'(code); cfg_last = last;
    set_pend(d, i, run, code, last);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // driver: one frame; optional table write in slot wr_at (bit 0)
  task automatic run_frame(input int nslots, input bit gaps, input logic [4:0] rdy,
                           input int wr_at, input int wd, input int wi,
                           input int wrun, input int wcode, input bit wlast);
    int cyc = 0;
    int rc = 0;
    logic [7:0] rb;
    tx_rdy = rdy;
    exp_ur = '0;
    fid++;
    for (int s = 0; s < nslots; s++) begin
      for (int b = 0; b < 8; b++) begin
        if (gaps && (cyc % 3 == 2)) begin
          @(negedge clk);
          cfg_we = 1'b0; bit_en = 1'b0; frame_start = 1'b0; rx_bit = ~rx_bit;
        end
        cyc++;
        @(negedge clk);
        cfg_we = 1'b0;
        if (s == 0 && b == 0) begin
          a_run = p_run; a_code = p_code; a_last = p_last;
          exp_ur = '0;
        end
        if (b == 0) begin
          int tc;
          tc = model_chan(1, s);
          for (int c = 0; c < 5; c++) tx_din[c*8 +: 8] = din_val(c, s);
          txq_ch.push_back(tc);
          if (tc == 0) begin
            txq_take.push_back(0); txq_b.push_back(8'hFF); txq_en.push_back(0);
          end else if (rdy[tc-1]) begin
            txq_take.push_back(1 << (tc - 1)); txq_b.push_back(din_val(tc - 1, s)); txq_en.push_back(1);
          end else begin
            txq_take.push_back(0); txq_b.push_back(8'hFF); txq_en.push_back(1);
            exp_ur[tc-1] = 1'b1;
          end
          rc = model_chan(0, s);
        end
        if (s == wr_at && b == 0) begin
          cfg_we = 1'b1; cfg_dir = wd[0]; cfg_idx = 6'(wi); cfg_run = 6'(wrun);
          cfg_code = 3'(wcode); cfg_last = wlast;
          set_pend(wd, wi, wrun, wcode, wlast);
        end
        rb = rx_val(s);
        bit_en = 1'b1; bit_idx = 3'(b); frame_start = (s == 0 && b == 0); rx_bit = rb[7-b];
        if (b == 7 && rc != 0) begin
          rxq_ch.push_back(rc); rxq_b.push_back(rb);
        end
      end
    end
    @(negedge clk);
    bit_en = 1'b0; frame_start = 1'b0; cfg_we = 1'b0;
    @(negedge clk);
    check(tx_underrun == exp_ur, "R6", "underrun flags at frame end", tx_underrun, exp_ur);
  endtask

  // monitor: scoreboard side
  initial begin
    logic be;
    logic [2:0] bi;
    logic [7:0] acc;
    bit en_ok;
    logic last_bit, last_en;
    acc = '0; en_ok = 1'b1; last_bit = 1'b1; last_en = 1'b0;
    forever begin
      @(posedge clk);
      be = bit_en; bi = bit_idx;
      @(negedge clk);
      #1;
      if (rst_n !== 1'b1) begin
        last_bit = tx_bit; last_en = tx_en;
        continue;
      end
      if (rx_stb != 0) begin
        if (rxq_ch.size() == 0) check(1'b0, "R3", "strobe on unused slot", rx_stb, 0);
        else begin
          int ch;
          logic [7:0] eb;
          ch = rxq_ch.pop_front(); eb = rxq_b.pop_front();
          check(rx_stb == 5'(1 << (ch - 1)), "R2", "rx strobe channel", rx_stb, 1 << (ch - 1));
          check(rx_byte == eb, "R2", "rx byte MSB first", rx_byte, eb);
        end
      end
      if (!be) begin
        // R9: stalled cycle leaves the line and strobes untouched
        check(tx_bit == last_bit && tx_en == last_en && rx_stb == 0 && tx_take == 0,
              "R9", "hold during bit_en low", {tx_bit, tx_en}, {last_bit, last_en});
      end else begin
        if (txq_ch.size() == 0) check(1'b0, "R5", "tx slot without expectation", 0, 1);
        else begin
          if (bi == 0) begin
            acc = '0; en_ok = 1'b1;
            check(tx_take == 5'(txq_take[0]), "R5", "tx_take pulse", tx_take, txq_take[0]);
          end
          acc = {acc[6:0], tx_bit};
          if (tx_en != txq_en[0][0]) en_ok = 1'b0;
          if (bi == 7) begin
            int ch, en;
            logic [7:0] eb;
            string rq;
            ch = txq_ch.pop_front(); en = txq_en.pop_front(); eb = txq_b.pop_front();
            void'(txq_take.pop_front());
            rq = (ch == 0) ? "R3" : ((eb == 8'hFF && en == 1 && acc == 8'hFF) ? "R6" : "R5");
            check(acc == eb, rq, "tx byte", acc, eb);
            check(en_ok, rq, "tx_en over slot", en_ok, 1);
          end
        end
      end
      last_bit = tx_bit; last_en = tx_en;
    end
  end

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int d = 0; d < 2; d++)
      for (int i = 0; i < 64; i++) begin
        set_pend(d, i, 0, 0, 1'b1);
        a_run[d][i] = 0; a_code[d][i] = 0; a_last[d][i] = 1'b1;
      end
    rst_n = 1'b0; bit_en = 1'b0; bit_idx = '0; frame_start = 1'b0; rx_bit = 1'b0;
    cfg_we = 1'b0; cfg_dir = 1'b0; cfg_idx = '0; cfg_run = '0; cfg_code = '0; cfg_last = 1'b0;
    tx_din = '0; tx_rdy = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(rx_stb == 0 && tx_take == 0, "R10", "strobes after reset", {rx_stb, tx_take}, 0);
    check(tx_bit == 1'b1 && tx_en == 1'b0, "R10", "line idle after reset", {tx_bit, tx_en}, 2);
    check(tx_underrun == 0, "R10", "underrun after reset", tx_underrun, 0);
    // R10: untouched tables leave every slot unused
    run_frame(10, 1'b0, 5'b11111, -1, 0, 0, 0, 0, 1'b0);

    // R1 R3 R4 R7: differing rx/tx run tables, illegal code, trailing slots
    cfg_write(0, 0, 1, 0, 1'b0);
    cfg_write(0, 1, 2, 1, 1'b0);
    cfg_write(0, 2, 0, 6, 1'b0);
    cfg_write(0, 3, 1, 3, 1'b0);
    cfg_write(0, 4, 0, 5, 1'b1);
    cfg_write(1, 0, 0, 2, 1'b0);
    cfg_write(1, 1, 3, 4, 1'b0);
    cfg_write(1, 2, 1, 0, 1'b0);
    cfg_write(1, 3, 2, 1, 1'b1);
    run_frame(14, 1'b0, 5'b11111, -1, 0, 0, 0, 0, 1'b0);
    // R9 R6: stalls and channels 1 and 4 not ready
    run_frame(14, 1'b1, 5'b10110, -1, 0, 0, 0, 0, 1'b0);
    // R6: flags clear at the next frame start
    run_frame(14, 1'b0, 5'b11111, -1, 0, 0, 0, 0, 1'b0);

    // R8: mid-frame write applies from the next frame
    run_frame(14, 1'b0, 5'b11111, 3, 0, 1, 2, 2, 1'b0);
    run_frame(14, 1'b0, 5'b11111, -1, 0, 0, 0, 0, 1'b0);
    // R8: write in the frame-start cycle waits one more frame
    run_frame(14, 1'b0, 5'b11111, 0, 1, 0, 0, 5, 1'b0);
    run_frame(14, 1'b0, 5'b11111, -1, 0, 0, 0, 0, 1'b0);
    run_frame(14, 1'b1, 5'b01111, -1, 0, 0, 0, 0, 1'b0);

    // R11 R4: 64-slot run on rx, full 64-entry table on tx
    cfg_write(0, 0, 63, 3, 1'b0);
    cfg_write(0, 1, 0, 4, 1'b1);
    for (int i = 0; i < 64; i++) cfg_write(1, i, 0, (i % 5) + 1, 1'b0);
    run_frame(70, 1'b0, 5'b11111, -1, 0, 0, 0, 0, 1'b0);
    run_frame(70, 1'b0, 5'b11011, -1, 0, 0, 0, 0, 1'b0);

    repeat (4) @(negedge clk);
    check(rxq_ch.size() == 0, "R2", "rx bytes left undelivered", rxq_ch.size(), 0);
    check(txq_ch.size() == 0, "R5", "tx slots left unchecked", txq_ch.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule